// File: doc/BRIEF.md
# I2C EEPROM Slave Write Engine

This block is the bus-side protocol engine of a small two-wire serial EEPROM slave with a 512-byte array split into two 256-byte halves. It samples the SCL and SDA lines and finds start and stop conditions. After a start it takes in a device-select byte, an 8-bit word address and any number of data bytes, and it pulls SDA low for the acknowledge bit after each byte it accepts. Each accepted data byte goes to the page-buffer unit as a one-cycle write request that carries a 9-bit array address. A stop that ends a transfer with at least one accepted data byte sends a one-cycle commit pulse, which starts the internal nonvolatile program cycle.

The page-buffer unit reports a running program cycle on `busy_i`. While that input is high the engine acknowledges nothing, so a master can poll for completion: it repeats start plus a write-mode device-select until it gets an acknowledge. When the write-protect input is high and the transfer targets the upper half, the engine still acknowledges both address bytes. It then refuses the first data byte, and no commit follows at stop.

Top module: `i2c_ee_wr_engine`

## Requirements
- R1: After reset, `sda_oe`, `wr_valid` and `commit` are all low.
- R2: A device-select byte (MSB first) is acknowledged only if all of these hold: bits [7:4] equal 4'b1010, bits [3:2] equal `pin_a`, and bit 0 (R/W) is 0. Any other device-select byte gets no acknowledge, and every later byte gets none until the next start.
- R3: After an accepted device-select byte, the next byte is the word address, and it is acknowledged. Device-select bit 1 selects the array half and becomes `wr_addr[8]`.
- R4: Each data byte after the word address is acknowledged and produces one `wr_valid` pulse. That pulse carries the byte on `wr_data` and {half, current word address} on `wr_addr`. The word address then advances by one.
- R5: The word address advances only within a 16-byte page. Bits [3:0] wrap from 15 to 0 and bits [7:4] stay unchanged, so a 17th byte overwrites the first location.
- R6: A stop (SDA rising while SCL is high) gives exactly one `commit` pulse if at least one data byte was accepted since the last start. A stop with no accepted data byte gives no pulse.
- R7: While `busy_i` is high, a device-select byte gets no acknowledge and no request or commit is produced. Once `busy_i` is low, the same byte is acknowledged.
- R8: With `wp_i` high and half select 1, the device-select and word-address bytes are acknowledged. The first data byte is not acknowledged and produces no request, and the following stop produces no commit. With half select 0, `wp_i` has no effect.
- R9: A start (SDA falling while SCL is high) at any point, including in the middle of a transfer, begins a new device-select byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low (open-drain acknowledge) |
| pin_a | input | 2 | Hardware address pin levels |
| wp_i | input | 1 | Write-protect level for the upper half |
| busy_i | input | 1 | Internal program cycle in progress |
| wr_valid | output | 1 | One-cycle write request to the page buffer |
| wr_addr | output | 9 | Array address of the request |
| wr_data | output | 8 | Data byte of the request |
| commit | output | 1 | One-cycle pulse that starts the program cycle |

## Verification
The bench builds the block with its defaults: a two-stage line synchronizer and a 16-byte page (4 page bits). A transfer of 18 bytes therefore crosses the page end and reaches the wrap back to offset 0, and it overwrites the first two locations. Each SCL phase lasts 8 clocks, which gives enough margin over the synchronizer latency that an acknowledge is present before the master samples it and released before the next data bit is driven. The bench uses pin setting 2'b01. With that setting, device-select bytes with a wrong prefix, wrong pins or a read bit, busy polling, both protected and unprotected halves, and a repeated start in the middle of a transfer are all reachable.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DEV   = 2'd1,
    PH_WADDR = 2'd2,
    PH_DATA  = 2'd3
  } phase_t;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_s
);

  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_d;
  logic              sda_d;
  logic              scl_s;

  // synchronizer chain, idle bus level after reset
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q[0] <= 1'b1;
          sda_q[0] <= 1'b1;
        end else begin
          scl_q[0] <= scl_i;
          sda_q[0] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q[g] <= 1'b1;
          sda_q[g] <= 1'b1;
        end else begin
          scl_q[g] <= scl_q[g-1];
          sda_q[g] <= sda_q[g-1];
        end
      end
    end
  end

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_d;
    scl_fall  = ~scl_s & scl_d;
    start_det = scl_s & scl_d & sda_d & ~sda_s;
    stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  end

endmodule

// File: rtl/i2c_bit_shift.sv
module i2c_bit_shift #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            active,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            sda_s,
  output logic            byte_done,
  output logic            ack_end,
  output logic            in_ack,
  output logic [BITS-1:0] rx_byte
);

  localparam int CW = $clog2(BITS + 2);
  localparam logic [CW-1:0] LAST = CW'(BITS);
  localparam logic [CW-1:0] SLOT = CW'(BITS + 1);

  logic [CW-1:0]   cnt_q, cnt_n;
  logic [BITS-1:0] sh_q, sh_n;

  always_comb begin
    cnt_n     = cnt_q;
    sh_n      = sh_q;
    byte_done = 1'b0;
    ack_end   = 1'b0;
    if (clear || !active) begin
      cnt_n = '0;
    end else if (scl_rise && (cnt_q < LAST)) begin
      sh_n  = {sh_q[BITS-2:0], sda_s};
      cnt_n = cnt_q + 1'b1;
    end else if (scl_fall && (cnt_q == LAST)) begin
      byte_done = 1'b1;
      cnt_n     = SLOT;
    end else if (scl_fall && (cnt_q == SLOT)) begin
      ack_end = 1'b1;
      cnt_n   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
    end
  end

  assign in_ack  = (cnt_q == SLOT);
  assign rx_byte = sh_q;

  assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SLOT);

endmodule

// File: rtl/i2c_wr_ctrl.sv
module i2c_wr_ctrl
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4,
  parameter int PIN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_done,
  input  logic              ack_end,
  input  logic              in_ack,
  input  logic [ADDR_W-1:0] rx_byte,
  input  logic [PIN_W-1:0]  pin_a,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              active,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [ADDR_W:0]   wr_addr,
  output logic [ADDR_W-1:0] wr_data,
  output logic              commit
);

  localparam int PIN_LO = 2;
  localparam int PIN_HI = PIN_LO + PIN_W - 1;

  phase_t            ph_q, ph_n;
  logic              blk_q, blk_n;
  logic              prot_q, prot_n;
  logic              seen_q, seen_n;
  logic              oe_q, oe_n;
  logic [ADDR_W-1:0] wa_q, wa_n;
  logic              wv_n, cm_n;
  logic [ADDR_W:0]   wad_n;
  logic [ADDR_W-1:0] wd_n;
  logic              sel_match;

  assign sel_match = (rx_byte[7:4] == DEV_PREFIX) &&
                     (rx_byte[PIN_HI:PIN_LO] == pin_a) && !rx_byte[0];

  always_comb begin
    ph_n   = ph_q;
    blk_n  = blk_q;
    prot_n = prot_q;
    seen_n = seen_q;
    oe_n   = oe_q;
    wa_n   = wa_q;
    wv_n   = 1'b0;
    cm_n   = 1'b0;
    wad_n  = wr_addr;
    wd_n   = wr_data;
    if (start_det) begin
      ph_n   = PH_DEV;
      oe_n   = 1'b0;
      seen_n = 1'b0;
    end else if (stop_det) begin
      cm_n   = (ph_q == PH_DATA) && seen_q && !busy_i;
      ph_n   = PH_IDLE;
      oe_n   = 1'b0;
      seen_n = 1'b0;
    end else if (ack_end) begin
      oe_n = 1'b0;
    end else if (byte_done) begin
      unique case (ph_q)
        PH_DEV: begin
          if (sel_match && !busy_i) begin
            oe_n  = 1'b1;
            blk_n = rx_byte[1];
            ph_n  = PH_WADDR;
          end else begin
            ph_n = PH_IDLE;
          end
        end
        PH_WADDR: begin
          oe_n   = 1'b1;
          wa_n   = rx_byte;
          prot_n = wp_i & blk_q;
          ph_n   = PH_DATA;
        end
        PH_DATA: begin
          if (prot_q) begin
            ph_n = PH_IDLE;
          end else begin
            oe_n   = 1'b1;
            wv_n   = 1'b1;
            wd_n   = rx_byte;
            wad_n  = {blk_q, wa_q};
            wa_n   = {wa_q[ADDR_W-1:PAGE_W], wa_q[PAGE_W-1:0] + PAGE_W'(1)};
            seen_n = 1'b1;
          end
        end
        default: ph_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      blk_q    <= 1'b0;
      prot_q   <= 1'b0;
      seen_q   <= 1'b0;
      oe_q     <= 1'b0;
      wa_q     <= '0;
      wr_valid <= 1'b0;
      commit   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      ph_q     <= ph_n;
      blk_q    <= blk_n;
      prot_q   <= prot_n;
      seen_q   <= seen_n;
      oe_q     <= oe_n;
      wa_q     <= wa_n;
      wr_valid <= wv_n;
      commit   <= cm_n;
      if (wv_n) begin
        wr_addr <= wad_n;
        wr_data <= wd_n;
      end
    end
  end

  assign sda_oe = oe_q;
  assign active = (ph_q != PH_IDLE);

  assert_oe_in_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> in_ack);

  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_commit_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  assert_busy_no_sel_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && (ph_q == PH_WADDR)) |-> !$past(busy_i));

  assert_refused_no_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !$past(prot_q));

endmodule

// File: rtl/i2c_ee_wr_engine.sv
module i2c_ee_wr_engine #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int PIN_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [PIN_W-1:0]  pin_a,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              wr_valid,
  output logic [ADDR_W:0]   wr_addr,
  output logic [ADDR_W-1:0] wr_data,
  output logic              commit
);

  logic scl_rise, scl_fall, start_det, stop_det, sda_s;
  logic byte_done, ack_end, in_ack, active;
  logic [ADDR_W-1:0] rx_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s)
  );

  i2c_bit_shift #(.BITS(ADDR_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_det),
    .active    (active),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .byte_done (byte_done),
    .ack_end   (ack_end),
    .in_ack    (in_ack),
    .rx_byte   (rx_byte)
  );

  i2c_wr_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PIN_W(PIN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_det (start_det),
    .stop_det  (stop_det),
    .byte_done (byte_done),
    .ack_end   (ack_end),
    .in_ack    (in_ack),
    .rx_byte   (rx_byte),
    .pin_a     (pin_a),
    .wp_i      (wp_i),
    .busy_i    (busy_i),
    .active    (active),
    .sda_oe    (sda_oe),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .commit    (commit)
  );

endmodule

// File: tb/sim_i2c_ee_wr_engine.sv
`timescale 1ns/1ps
module sim_i2c_ee_wr_engine;

  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [1:0] pins = 2'b01;
  logic wp = 1'b0;
  logic busy = 1'b0;
  logic sda_oe, wr_valid, commit;
  logic [8:0] wr_addr;
  logic [7:0] wr_data;
  logic sda_line;

  always #5 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  i2c_ee_wr_engine u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .pin_a(pins), .wp_i(wp), .busy_i(busy),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit)
  );

  int compared = 0;
  int mismatched = 0;
  int exp_commits = 0;
  int got_commits = 0;
  bit seg_seen = 1'b0;
  bit done = 1'b0;
  string cur_tag = "R4";
  logic [16:0] expq[$];

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // reference model side: request stream and commit count, every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wr_valid) begin
        if (expq.size() == 0) begin
          check(1'b0, cur_tag, {15'd0, wr_addr, wr_data}, 0);
        end else begin
          logic [16:0] e;
          e = expq.pop_front();
          check({wr_addr, wr_data} == e, cur_tag, {wr_addr, wr_data}, e);
        end
      end
      if (commit) got_commits++;
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    if (!m_scl) begin
      wq(); m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
    end else begin
      m_sda = 1'b1; wq();
    end
    m_sda = 1'b0; wq(); m_scl = 1'b0;
    seg_seen = 1'b0;
  endtask

  task automatic bus_stop();
    wq(); m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    if (seg_seen) exp_commits++;
    seg_seen = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      wq(); m_sda = b[i]; wq(); m_scl = 1'b1; wq();
      check(sda_oe == 1'b0, "R2 no drive in data bit", sda_oe, 0);
      wq(); m_scl = 1'b0;
    end
    wq(); m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
    acked = sda_oe;
    wq(); m_scl = 1'b0;
  endtask

  // one transfer from the master with behavioural expectations
  task automatic txn(input logic [7:0] dev, input logic [7:0] wa, input int n,
                     input logic [7:0] d0, input bit do_stop, input string tag);
    bit ok, a;
    bit blk;
    logic [7:0] addr;
    ok   = (dev[7:4] == 4'b1010) && (dev[3:2] == pins) && !dev[0] && !busy;
    blk  = dev[1];
    addr = wa;
    bus_start();
    send_byte(dev, a);
    check(a == ok, {tag, " R2 select ack"}, a, ok);
    send_byte(wa, a);
    check(a == ok, {tag, " R3 address ack"}, a, ok);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      bit e;
      d = d0 + 8'(i * 7);
      e = ok && !(wp && blk);
      if (e) expq.push_back({blk, addr, d});
      send_byte(d, a);
      check(a == e, {tag, " R4 data ack"}, a, e);
      if (e) begin
        addr = {addr[7:4], addr[3:0] + 4'd1};
        seg_seen = 1'b1;
      end
      if (ok && !e) break;
    end
    if (do_stop) begin
      bus_stop();
      repeat (20) @(negedge clk);
      check(expq.size() == 0, {tag, " R4 all requests seen"}, expq.size(), 0);
      check(got_commits == exp_commits, {tag, " R6 commit count"}, got_commits, exp_commits);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0 && wr_valid == 1'b0 && commit == 1'b0, "R1 reset outputs",
          {sda_oe, wr_valid, commit}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0 && wr_valid == 1'b0 && commit == 1'b0, "R1 after release",
          {sda_oe, wr_valid, commit}, 0);

    cur_tag = "R4";
    txn(8'hA4, 8'h12, 1, 8'hA5, 1'b1, "byte write");
    txn(8'hA6, 8'hC7, 3, 8'h30, 1'b1, "R3 upper half page");
    cur_tag = "R5";
    txn(8'hA4, 8'h3E, 18, 8'h01, 1'b1, "R5 page wrap");
    cur_tag = "R2";
    txn(8'hB4, 8'h10, 2, 8'h55, 1'b1, "R2 bad prefix");
    txn(8'hA8, 8'h10, 2, 8'h55, 1'b1, "R2 bad pins");
    txn(8'hA5, 8'h10, 2, 8'h55, 1'b1, "R2 read bit");
    cur_tag = "R6";
    txn(8'hA4, 8'h20, 0, 8'h00, 1'b1, "R6 no data stop");

    cur_tag = "R7";
    busy = 1'b1;
    txn(8'hA4, 8'h40, 2, 8'h11, 1'b1, "R7 busy poll");
    busy = 1'b0;
    txn(8'hA4, 8'h40, 1, 8'h22, 1'b1, "R7 after busy");

    cur_tag = "R8";
    wp = 1'b1;
    txn(8'hA6, 8'h80, 2, 8'h33, 1'b1, "R8 protected upper");
    txn(8'hA4, 8'h80, 2, 8'h44, 1'b1, "R8 lower unaffected");
    wp = 1'b0;

    cur_tag = "R9";
    txn(8'hA4, 8'h50, 1, 8'h66, 1'b0, "R9 first part");
    txn(8'hA6, 8'h05, 2, 8'h77, 1'b1, "R9 after restart");
    txn(8'hA4, 8'h60, 1, 8'h88, 1'b0, "R9 restart abort");
    txn(8'hB0, 8'h00, 0, 8'h00, 1'b1, "R9 restart bad select");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule